// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block is the controller-side engine that owns the SDRAM command pins from reset onwards. It waits a programmable power-up interval with the command decoder deselected and the clock enable low. It then closes every bank, runs two auto refresh cycles and programs the mode register with a fixed op-code, each step followed by its own timed wait. Once the mode register wait ends it raises a ready flag and hands ordinary traffic to the rest of the controller.

After initialization it keeps a refresh interval timer. Each time the interval runs out it adds one refresh to a small debt counter and raises a request towards the bus arbiter. A grant seen while idle makes it issue one AUTO REFRESH, reload the timer and hold busy for the row-cycle time. A debt of several refreshes is paid back with back-to-back refreshes. A self-refresh request moves the device into self refresh (auto-refresh encoding with clock enable low), keeps it there for at least the minimum hold, and on release raises clock enable and sends NOPs for the exit time before returning to idle. Every delay is a parameter in clock cycles.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: From reset release until cycle POWERUP_CYC-1, the pins show the deselect command ({cs_n,ras_n,cas_n,we_n}=4'b1111) with cke_o low, and ready_o is low.
- R2: In cycle POWERUP_CYC the block drives cke_o high and issues PRECHARGE (4'b0010) with address bit AP_BIT (bit 10 by default) high and all other address and bank bits zero.
- R3: Exactly T_RP cycles after the precharge, and again T_RC cycles later, it issues AUTO REFRESH (4'b0001) with cke_o high; every other cycle of the sequence is NOP (4'b0111).
- R4: T_RC cycles after the second refresh it issues LOAD MODE (4'b0000) with {ba_o,addr_o} equal to MODE_OP; ready_o rises T_MRD cycles later and stays high.
- R5: refresh_req_o rises exactly REFI_CYC cycles after ready_o rises, and REFI_CYC cycles after each issued refresh or each earlier expiry.
- R6: While idle with a refresh owed, grant_i high at a clock edge makes AUTO REFRESH appear in the following cycle; refresh_req_o stays high until then, and a grant with no debt or while busy has no effect.
- R7: busy_o is high for exactly T_RC cycles starting with the cycle that carries a normal AUTO REFRESH, and only NOPs are issued in that window.
- R8: Up to MAX_OWED expiries are owed without a grant; a grant held high then produces exactly that many refreshes, T_RC+1 cycles apart, after which refresh_req_o falls.
- R9: A self-refresh request while idle issues the refresh encoding with cke_o low, sets in_self_ref_o, and keeps cke_o low for at least T_RAS cycles even when the request drops at once.
- R10: On leaving self refresh cke_o rises and T_XSR NOP cycles follow with busy_o high; the debt is cleared and the interval timer restarts, so the next request comes REFI_CYC cycles after idle is reached.
- R11: A self-refresh request takes priority over an owed refresh with grant_i high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Arbiter grant for a pending refresh |
| self_ref_req_i | input | 1 | Level request to be in self refresh |
| refresh_req_o | output | 1 | At least one refresh is owed |
| busy_o | output | 1 | Refresh, self refresh or self-refresh exit in progress |
| ready_o | output | 1 | Initialization complete |
| in_self_ref_o | output | 1 | Device held in self refresh |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |

## Verification
Every pin is registered, so a grant or self-refresh request sampled at edge n shows its command in cycle n, the first cycle after that edge, and busy, ready and self-refresh flags change in that same cycle. The initialization commands fall at fixed cycle numbers (POWERUP_CYC, plus T_RP, plus T_RC twice, plus T_MRD for ready), and the refresh request rises REFI_CYC cycles after each restart point. The bench drives inputs on falling edges, advances a timing model on every rising edge and compares all outputs on the next falling edge, so each expected value lands in exactly the cycle it is due. Scenario checks add counts of hold and exit durations and of refreshes paid back from a saturated debt.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD_MODE = 4'b0000,
    CMD_REFRESH   = 4'b0001,
    CMD_PRECHARGE = 4'b0010,
    CMD_NOP       = 4'b0111,
    CMD_INHIBIT   = 4'b1111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_POWERUP,
    ST_PRECHG,
    ST_INIT_REF1,
    ST_INIT_REF2,
    ST_LOAD_MODE,
    ST_IDLE,
    ST_REFRESH,
    ST_SELF_REF,
    ST_SR_EXIT
  } seq_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RST_VAL;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_ref_sched.sv
module sdram_ref_sched #(
  parameter int unsigned REFI_CYC = 780,
  parameter int unsigned MAX_OWED = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic issue_i,
  output logic due_o
);

  localparam int unsigned TW = $clog2(REFI_CYC + 1);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);
  localparam logic [TW-1:0] RELOAD   = TW'(REFI_CYC - 1);
  localparam logic [OW-1:0] OWED_TOP = OW'(MAX_OWED);

  logic [TW-1:0] tmr_q;
  logic [OW-1:0] owed_q;

  // R5/R8: reload on issue or expiry; an expiry on the issue edge is absorbed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= RELOAD;
      owed_q <= '0;
    end else if (!run_i) begin
      tmr_q  <= RELOAD;
      owed_q <= '0;
    end else if (issue_i) begin
      tmr_q  <= RELOAD;
      owed_q <= owed_q - OW'(1);
    end else if (tmr_q == '0) begin
      tmr_q <= RELOAD;
      if (owed_q != OWED_TOP) owed_q <= owed_q + OW'(1);
    end else begin
      tmr_q <= tmr_q - TW'(1);
    end
  end

  assign due_o = (owed_q != '0);

endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BA_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic              cke_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BA_W-1:0]   ba_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= CMD_INHIBIT;
      cke_o  <= 1'b0;
      addr_o <= '0;
      ba_o   <= '0;
    end else begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= cmd_i;
      cke_o  <= cke_i;
      addr_o <= addr_i;
      ba_o   <= ba_i;
    end
  end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BA_W        = 1,
  parameter int unsigned AP_BIT      = 10,
  parameter int unsigned POWERUP_CYC = 5000,
  parameter int unsigned T_RP        = 3,
  parameter int unsigned T_RC        = 5,
  parameter int unsigned T_MRD       = 2,
  parameter int unsigned T_RAS       = 4,
  parameter int unsigned T_XSR       = 6,
  parameter int unsigned REFI_CYC    = 780,
  parameter int unsigned MAX_OWED    = 4,
  parameter logic [BA_W+ADDR_W-1:0] MODE_OP = 12'h022
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_i,
  input  logic              self_ref_req_i,
  output logic              refresh_req_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              in_self_ref_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned MAX_WAIT =
    max2(max2(max2(POWERUP_CYC, T_RP), max2(T_RC, T_MRD)), max2(T_RAS, T_XSR));
  localparam int unsigned WAIT_W = $clog2(MAX_WAIT + 1);

  seq_state_e        st_q, st_d;
  logic              tmr_zero, tmr_ld;
  logic [WAIT_W-1:0] tmr_val;
  logic              ref_due, ref_issue, sched_run;
  cmd_e              cmd_d;
  logic              cke_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;

  sdram_seq_timer #(
    .W       (WAIT_W),
    .RST_VAL (WAIT_W'(POWERUP_CYC - 1))
  ) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_ld),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign sched_run = (st_q == ST_IDLE) || (st_q == ST_REFRESH);

  sdram_ref_sched #(
    .REFI_CYC (REFI_CYC),
    .MAX_OWED (MAX_OWED)
  ) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (sched_run),
    .issue_i (ref_issue),
    .due_o   (ref_due)
  );

  always_comb begin
    st_d      = st_q;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    ref_issue = 1'b0;
    cmd_d     = CMD_NOP;
    addr_d    = '0;
    ba_d      = '0;
    unique case (st_q)
      ST_POWERUP: begin
        cmd_d = CMD_INHIBIT;                               // R1
        if (tmr_zero) begin
          st_d           = ST_PRECHG;
          cmd_d          = CMD_PRECHARGE;                  // R2: all banks
          addr_d[AP_BIT] = 1'b1;
          tmr_ld         = 1'b1;
          tmr_val        = WAIT_W'(T_RP - 1);
        end
      end
      ST_PRECHG: if (tmr_zero) begin
        st_d    = ST_INIT_REF1;
        cmd_d   = CMD_REFRESH;                             // R3
        tmr_ld  = 1'b1;
        tmr_val = WAIT_W'(T_RC - 1);
      end
      ST_INIT_REF1: if (tmr_zero) begin
        st_d    = ST_INIT_REF2;
        cmd_d   = CMD_REFRESH;
        tmr_ld  = 1'b1;
        tmr_val = WAIT_W'(T_RC - 1);
      end
      ST_INIT_REF2: if (tmr_zero) begin
        st_d           = ST_LOAD_MODE;
        cmd_d          = CMD_LOAD_MODE;                    // R4
        {ba_d, addr_d} = MODE_OP;
        tmr_ld         = 1'b1;
        tmr_val        = WAIT_W'(T_MRD - 1);
      end
      ST_LOAD_MODE: if (tmr_zero) st_d = ST_IDLE;
      ST_IDLE: begin
        if (self_ref_req_i) begin                          // R11: wins over refresh
          st_d    = ST_SELF_REF;
          cmd_d   = CMD_REFRESH;
          tmr_ld  = 1'b1;
          tmr_val = WAIT_W'(T_RAS - 1);
        end else if (ref_due && grant_i) begin             // R6
          ref_issue = 1'b1;
          st_d      = ST_REFRESH;
          cmd_d     = CMD_REFRESH;
          tmr_ld    = 1'b1;
          tmr_val   = WAIT_W'(T_RC - 1);
        end
      end
      ST_REFRESH: if (tmr_zero) st_d = ST_IDLE;            // R7
      ST_SELF_REF: if (tmr_zero && !self_ref_req_i) begin  // R9 hold, R10 exit
        st_d    = ST_SR_EXIT;
        tmr_ld  = 1'b1;
        tmr_val = WAIT_W'(T_XSR - 1);
      end
      ST_SR_EXIT: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_POWERUP;
    endcase
    cke_d = !((st_d == ST_POWERUP) || (st_d == ST_SELF_REF));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_POWERUP;
    else         st_q <= st_d;
  end

  sdram_cmd_reg #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_d),
    .cke_i   (cke_d),
    .addr_i  (addr_d),
    .ba_i    (ba_d),
    .cke_o   (cke_o),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .addr_o  (addr_o),
    .ba_o    (ba_o)
  );

  assign refresh_req_o = ref_due;
  assign ready_o       = st_q inside {ST_IDLE, ST_REFRESH, ST_SELF_REF, ST_SR_EXIT};
  assign busy_o        = st_q inside {ST_REFRESH, ST_SELF_REF, ST_SR_EXIT};
  assign in_self_ref_o = (st_q == ST_SELF_REF);

endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned AP_BIT = 10,
  parameter int unsigned T_RAS  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              grant_i,
  input logic              self_ref_req_i,
  input logic              busy_o,
  input logic              ready_o,
  input logic              in_self_ref_o,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o
);

  logic [3:0]  cmd;
  logic [15:0] low_len_q;

  assign cmd = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        low_len_q <= '0;
    else if (cke_o)                     low_len_q <= '0;
    else if (low_len_q != 16'hffff)     low_len_q <= low_len_q + 16'd1;
  end

  p_inhibit_powerup_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !ready_o) |-> cs_n_o);

  p_prechg_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0010) |-> addr_o[AP_BIT]);

  p_ready_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_ref_after_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cke_o && cmd == 4'b0001) |-> $past(grant_i));

  p_busy_on_ref_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cke_o && cmd == 4'b0001) |-> busy_o);

  p_sr_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !cke_o && $past(cke_o)) |-> (cmd == 4'b0001));

  p_sr_cke_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_self_ref_o |-> !cke_o);

  p_sr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cke_o && $past(!cke_o)) |-> (low_len_q >= 16'(T_RAS)));

  p_exit_nop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cke_o && $past(!cke_o)) |-> (cmd == 4'b0111));

  p_sr_priority_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(self_ref_req_i) && $past(ready_o && !busy_o)) |-> in_self_ref_o);

endmodule

bind sdram_init_refresh_seq sdram_seq_checker #(
  .ADDR_W (ADDR_W),
  .AP_BIT (AP_BIT),
  .T_RAS  (T_RAS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .grant_i        (grant_i),
  .self_ref_req_i (self_ref_req_i),
  .busy_o         (busy_o),
  .ready_o        (ready_o),
  .in_self_ref_o  (in_self_ref_o),
  .cke_o          (cke_o),
  .cs_n_o         (cs_n_o),
  .ras_n_o        (ras_n_o),
  .cas_n_o        (cas_n_o),
  .we_n_o         (we_n_o),
  .addr_o         (addr_o)
);

// File: tb/sdram_init_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq_tb;

  localparam int PWR  = 5000;
  localparam int RP   = 3;
  localparam int RC   = 5;
  localparam int MRD  = 2;
  localparam int RAS  = 4;
  localparam int XSR  = 6;
  localparam int REFI = 780;
  localparam int OWE  = 4;
  localparam logic [11:0] OPC = 12'h022;

  localparam int C_PRE = PWR;
  localparam int C_R1  = C_PRE + RP;
  localparam int C_R2  = C_R1 + RC;
  localparam int C_MRS = C_R2 + RC;
  localparam int C_RDY = C_MRS + MRD;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic grant_i = 1'b0;
  logic self_ref_req_i = 1'b0;
  logic refresh_req_o, busy_o, ready_o, in_self_ref_o;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [0:0]  ba_o;
  logic [10:0] addr_o;

  always #10 clk_i = ~clk_i;

  sdram_init_refresh_seq #(
    .POWERUP_CYC (PWR), .T_RP (RP), .T_RC (RC), .T_MRD (MRD),
    .T_RAS (RAS), .T_XSR (XSR), .REFI_CYC (REFI), .MAX_OWED (OWE),
    .MODE_OP (OPC)
  ) u_dut (
    .clk_i, .rst_ni, .grant_i, .self_ref_req_i, .refresh_req_o, .busy_o,
    .ready_o, .in_self_ref_o, .cke_o, .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o,
    .ba_o, .addr_o
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_ref = 0;
  int wd = 0;

  // behavioural timing model: 0 init, 1 idle, 2 refresh, 3 self refresh, 4 exit
  bit m_on = 1'b0;
  int m_cyc, mode, t0, owed, since;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, m_cyc, act, exp);
    end
  endtask

  always @(posedge clk_i) if (m_on) begin
    int n;
    bit run, issue;
    n     = m_cyc + 1;
    run   = (mode == 1) || (mode == 2);
    issue = (mode == 1) && !self_ref_req_i && (owed > 0) && grant_i;
    if (!run) begin
      since = 0; owed = 0;
    end else if (issue) begin
      since = 0; owed--;
    end else begin
      since++;
      if (since == REFI) begin
        since = 0;
        if (owed < OWE) owed++;
      end
    end
    case (mode)
      0: if (n == C_RDY) mode = 1;
      1: if (self_ref_req_i) begin mode = 3; t0 = n; end
         else if (issue) begin mode = 2; t0 = n; end
      2: if (n - t0 == RC) mode = 1;
      3: if ((n - t0 >= RAS) && !self_ref_req_i) begin mode = 4; t0 = n; end
      4: if (n - t0 == XSR) mode = 1;
      default: ;
    endcase
    m_cyc = n;
  end

  // per-cycle comparison of every output against the model
  always @(negedge clk_i) if (m_on) begin
    logic [3:0]  e_cmd;
    logic        e_cke;
    logic [11:0] e_ab;
    logic [19:0] got, exp;
    string tag;
    e_cmd = 4'b0111; e_cke = 1'b1; e_ab = '0;
    if (mode == 0) begin
      if (m_cyc < C_PRE) begin e_cmd = 4'b1111; e_cke = 1'b0; tag = "R1"; end
      else if (m_cyc < C_R1) tag = "R2";
      else if (m_cyc < C_MRS) tag = "R3";
      else tag = "R4";
      if (m_cyc == C_PRE) begin e_cmd = 4'b0010; e_ab = 12'h400; end
      if (m_cyc == C_R1 || m_cyc == C_R2) e_cmd = 4'b0001;
      if (m_cyc == C_MRS) begin e_cmd = 4'b0000; e_ab = OPC; end
    end else if (mode == 1) tag = "R6";
    else if (mode == 2) begin tag = "R7"; if (m_cyc == t0) e_cmd = 4'b0001; end
    else if (mode == 3) begin
      tag = "R9"; e_cke = 1'b0;
      if (m_cyc == t0) e_cmd = 4'b0001;
    end else tag = "R10";
    exp = {e_cke, e_cmd, e_ab, mode != 0, mode >= 2, mode == 3};
    got = {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o, ready_o, busy_o, in_self_ref_o};
    chk(got === exp, tag, int'(got), int'(exp));
    chk(refresh_req_o === (owed > 0), "R5 R8 refresh_req", int'(refresh_req_o), int'(owed > 0));
    if (ready_o && cke_o && {cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0001) n_ref++;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog R1..all: actual %0d expected below %0d cycles", wd, 150000);
      finish_run();
    end
  end

  task automatic cycles(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  initial begin
    int k, r0;
    cycles(3);
    rst_ni = 1'b1;
    #1;
    m_cyc = 0; mode = 0; owed = 0; since = 0; t0 = 0;
    // R1: reset state
    chk(cs_n_o == 1'b1, "R1 cs_n at reset", cs_n_o, 1);
    chk(cke_o == 1'b0, "R1 cke at reset", cke_o, 0);
    chk(ready_o == 1'b0, "R1 ready at reset", ready_o, 0);
    m_on = 1'b1;

    // R4: ready timing
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    chk(m_cyc == C_RDY, "R4 ready cycle", m_cyc, C_RDY);

    // R5: first request after ready
    k = 0;
    while (!refresh_req_o) begin @(negedge clk_i); k++; end
    chk(k == REFI, "R5 interval from ready", k, REFI);

    // R6/R7: delayed single grant
    cycles(3);
    chk(refresh_req_o == 1'b1, "R6 request held", refresh_req_o, 1);
    grant_i = 1'b1;
    @(negedge clk_i);
    grant_i = 1'b0;
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0001, "R6 refresh after grant",
        {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 1);
    chk(busy_o == 1'b1, "R7 busy on refresh", busy_o, 1);
    cycles(RC);
    chk(busy_o == 1'b0, "R7 busy drop after T_RC", busy_o, 0);
    chk(refresh_req_o == 1'b0, "R6 request cleared", refresh_req_o, 0);

    // R8: saturated debt paid back-to-back
    cycles(REFI * (OWE + 2));
    r0 = n_ref;
    grant_i = 1'b1;
    cycles(OWE * (RC + 1) + 10);
    grant_i = 1'b0;
    cycles(1);
    chk(n_ref - r0 == OWE, "R8 refreshes from saturated debt", n_ref - r0, OWE);
    chk(refresh_req_o == 1'b0, "R8 request after payback", refresh_req_o, 0);

    // R11/R9/R10: self refresh request against a pending granted refresh
    while (!refresh_req_o) @(negedge clk_i);
    r0 = n_ref;
    self_ref_req_i = 1'b1;
    grant_i = 1'b1;
    @(negedge clk_i);
    self_ref_req_i = 1'b0;
    grant_i = 1'b0;
    chk(in_self_ref_o == 1'b1, "R11 self refresh wins", in_self_ref_o, 1);
    chk(cke_o == 1'b0, "R9 cke low on entry", cke_o, 0);
    k = 0;
    while (in_self_ref_o) begin k++; @(negedge clk_i); end
    chk(k == RAS, "R9 minimum hold", k, RAS);
    chk(cke_o == 1'b1, "R10 cke raised on exit", cke_o, 1);
    k = 0;
    while (busy_o) begin k++; @(negedge clk_i); end
    chk(k == XSR, "R10 exit nop cycles", k, XSR);
    chk(n_ref == r0, "R11 pending refresh not issued", n_ref - r0, 0);
    chk(refresh_req_o == 1'b0, "R10 debt cleared", refresh_req_o, 0);

    // R10: long self refresh, timer restart
    self_ref_req_i = 1'b1;
    cycles(40);
    chk(in_self_ref_o == 1'b1, "R9 held while requested", in_self_ref_o, 1);
    self_ref_req_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    k = 0;
    while (!refresh_req_o) begin @(negedge clk_i); k++; end
    chk(k == REFI, "R10 interval restart", k, REFI);

    // R6: immediate grant, then grant while busy and with no debt
    grant_i = 1'b1;
    cycles(RC + 20);
    grant_i = 1'b0;
    chk(refresh_req_o == 1'b0, "R6 grant without debt", refresh_req_o, 0);
    cycles(2);
    finish_run();
  end

endmodule